// File: doc/BRIEF.md
# Single-Digit Frequency Readout Sequencer

This block shows a multi-digit tuned frequency on one 7-segment digit. It shows three chosen decimal digits one after another, each separated by a short dark gap. The first digit stays lit longer than the other two. A long dark interval then follows before the cycle repeats. All timing is counted in ticks of a one-millisecond strobe that the block receives as an input.

The tuning step size is held inside the block as a value from 1 to 6 and is driven out on the `speed` port for the tuning logic. This value decides which digits are shown. At speeds 5 and 6 the block shows the MHz tens digit, the MHz units digit and the 100 kHz digit. At speeds 1 to 4 it shows the three kHz digits.

While the up or down button is held, the display stays dark. When both are released, the cycle starts again at once from its first digit. While the speed button is held, the display shows the step-size value. Holding exactly one tuning button at the same time moves that value by one in the button's direction at a fixed interval. Debouncing is done upstream.

Top module: `freq_flash_display`

## Requirements
- R1: After reset, `speed` equals SPEED_INIT (default 3), and the display shows the first digit of the cycle with `blank` low.
- R2: With no buttons held, one cycle is: first digit for FIRST_MS ticks, dark for GAP_MS, second digit for NEXT_MS, dark for GAP_MS, third digit for NEXT_MS, dark for REST_MS. The cycle then repeats.
- R3: When `speed` is 5 or 6, the three digits shown are, in order, `mhz_tens`, `mhz_ones`, `khz_hund`.
- R4: When `speed` is 1 to 4, the three digits shown are, in order, `khz_hund`, `khz_tens`, `khz_ones`.
- R5: `seg` is active-high, with bit 0 = segment a through bit 6 = segment g. The codes for 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex). Whenever `blank` is high, `seg` is 0.
- R6: The display timers and the step timer advance only on clock edges where `ms_tick` is high. Otherwise the display holds its value.
- R7: With the speed button released, holding up or down keeps `blank` high from the next edge on, for as long as the button is held.
- R8: On the first edge after up and down are both released (speed button released), the cycle restarts at the first digit with a full FIRST_MS duration.
- R9: From the edge after the speed button is pressed, and for as long as it is held, the display shows the value on `speed`.
- R10: While the speed button and exactly one of up or down are held, `speed` moves by one in that direction every STEP_MS ticks. If both up and down are held, it does not change.
- R11: `speed` never goes above 6 or below 1. Stepping past either limit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-millisecond timing strobe |
| mhz_tens | input | 4 | BCD MHz tens digit |
| mhz_ones | input | 4 | BCD MHz units digit |
| khz_hund | input | 4 | BCD 100 kHz digit |
| khz_tens | input | 4 | BCD 10 kHz digit |
| khz_ones | input | 4 | BCD 1 kHz digit |
| up_btn | input | 1 | Tune-up button level |
| down_btn | input | 1 | Tune-down button level |
| speed_btn | input | 1 | Step-size button level |
| seg | output | 7 | Segment pattern, bit 0 = a .. bit 6 = g |
| blank | output | 1 | High when no digit is lit |
| speed | output | 3 | Current step size, 1 to 6 |

## Verification
The hardest case to reach is the digit selection at the wide speeds. The step size is internal, so it can only be changed by holding the speed button together with a tuning button for several step intervals. The bench therefore drives the speed through its saturation limits to reach 5 and 6, then releases everything and compares a full cycle against the MHz digits. Short timing parameters keep each full cycle to a few dozen clocks, so every phase boundary is compared cycle by cycle.

// File: rtl/freq_flash_display.sv
module freq_flash_display #(
  parameter int FIRST_MS   = 500,
  parameter int GAP_MS     = 100,
  parameter int NEXT_MS    = 300,
  parameter int REST_MS    = 5000,
  parameter int STEP_MS    = 500,
  parameter int SPEED_INIT = 3,
  parameter int WIDE_SPEED = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic [3:0] mhz_tens,
  input  logic [3:0] mhz_ones,
  input  logic [3:0] khz_hund,
  input  logic [3:0] khz_tens,
  input  logic [3:0] khz_ones,
  input  logic       up_btn,
  input  logic       down_btn,
  input  logic       speed_btn,
  output logic [6:0] seg,
  output logic       blank,
  output logic [2:0] speed
);
  localparam int M1   = (FIRST_MS > NEXT_MS) ? FIRST_MS : NEXT_MS;
  localparam int M2   = (M1 > GAP_MS) ? M1 : GAP_MS;
  localparam int MAXD = (M2 > REST_MS) ? M2 : REST_MS;
  localparam int CW   = $clog2(MAXD + 1);
  localparam int SW   = $clog2(STEP_MS + 1);

  typedef enum logic [2:0] {
    PH_D0, PH_G0, PH_D1, PH_G1, PH_D2, PH_REST, PH_HOLD, PH_SPEED
  } phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt, dur_m1;
  logic [SW-1:0] scnt;
  logic [2:0]    speed_q;
  logic [3:0]    digit;
  logic          wide, tuning, stepping;

  assign tuning   = up_btn | down_btn;
  assign stepping = speed_btn & (up_btn ^ down_btn);
  assign wide     = speed_q >= 3'(WIDE_SPEED);
  assign speed    = speed_q;

  always_comb begin
    case (phase)
      PH_D0:   dur_m1 = CW'(FIRST_MS - 1);
      PH_D1,
      PH_D2:   dur_m1 = CW'(NEXT_MS - 1);
      PH_REST: dur_m1 = CW'(REST_MS - 1);
      default: dur_m1 = CW'(GAP_MS - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_D0;
      cnt   <= '0;
    end else if (speed_btn) begin
      phase <= PH_SPEED;
      cnt   <= '0;
    end else if (tuning) begin
      phase <= PH_HOLD;
      cnt   <= '0;
    end else if (phase == PH_HOLD || phase == PH_SPEED) begin
      phase <= PH_D0;
      cnt   <= '0;
    end else if (ms_tick) begin
      if (cnt == dur_m1) begin
        cnt   <= '0;
        phase <= (phase == PH_REST) ? PH_D0 : phase_t'(phase + 3'd1);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      speed_q <= 3'(SPEED_INIT);
      scnt    <= '0;
    end else if (!stepping) begin
      scnt <= '0;
    end else if (ms_tick) begin
      if (scnt == SW'(STEP_MS - 1)) begin
        scnt <= '0;
        if (up_btn && speed_q != 3'd6)   speed_q <= speed_q + 3'd1;
        if (down_btn && speed_q != 3'd1) speed_q <= speed_q - 3'd1;
      end else begin
        scnt <= scnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (phase)
      PH_D0:    digit = wide ? mhz_tens : khz_hund;
      PH_D1:    digit = wide ? mhz_ones : khz_tens;
      PH_D2:    digit = wide ? khz_hund : khz_ones;
      PH_SPEED: digit = {1'b0, speed_q};
      default:  digit = 4'd0;
    endcase
  end

  assign blank = !(phase == PH_D0 || phase == PH_D1 || phase == PH_D2 || phase == PH_SPEED);

  always_comb begin
    seg = 7'h00;
    if (!blank) begin
      case (digit)
        4'd0: seg = 7'h3F;
        4'd1: seg = 7'h06;
        4'd2: seg = 7'h5B;
        4'd3: seg = 7'h4F;
        4'd4: seg = 7'h66;
        4'd5: seg = 7'h6D;
        4'd6: seg = 7'h7D;
        4'd7: seg = 7'h07;
        4'd8: seg = 7'h7F;
        4'd9: seg = 7'h6F;
        default: seg = 7'h00;
      endcase
    end
  end

  AST_SPEED_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    speed_q >= 3'd1 && speed_q <= 3'd6); // R11
  AST_STEP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(speed_q) |-> $past(speed_btn) && $past(up_btn ^ down_btn)); // R10
  AST_HOLD_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (tuning && !speed_btn) |=> blank); // R7
  AST_RELEASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD && !tuning && !speed_btn) |=> (phase == PH_D0 && cnt == '0)); // R8
  AST_TICK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ms_tick && !tuning && !speed_btn && phase != PH_HOLD && phase != PH_SPEED)
      |=> ($stable(phase) && $stable(cnt))); // R6
  AST_DARK_SEG: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> seg == 7'h00); // R5
endmodule

// File: tb/freq_flash_display_test.sv
module freq_flash_display_test;
  localparam int F = 5, G = 2, N = 3, RS = 8, ST = 4;
  localparam int PER = F + G + N + G + N + RS;

  logic clk = 0, rst_n = 0, ms_tick = 1;
  logic [3:0] mhz_tens = 4'd2, mhz_ones = 4'd1, khz_hund = 4'd3, khz_tens = 4'd4, khz_ones = 4'd5;
  logic up_btn = 0, down_btn = 0, speed_btn = 0;
  logic [6:0] seg;
  logic blank;
  logic [2:0] speed;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  freq_flash_display #(.FIRST_MS(F), .GAP_MS(G), .NEXT_MS(N), .REST_MS(RS), .STEP_MS(ST)) uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .mhz_tens(mhz_tens), .mhz_ones(mhz_ones), .khz_hund(khz_hund),
    .khz_tens(khz_tens), .khz_ones(khz_ones),
    .up_btn(up_btn), .down_btn(down_btn), .speed_btn(speed_btn),
    .seg(seg), .blank(blank), .speed(speed));

  function automatic logic [6:0] pat(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_at(input int p, input int a, input int b, input int c);
    if (p < F) return {1'b0, pat(a)};
    if (p < F + G) return 8'h80;
    if (p < F + G + N) return {1'b0, pat(b)};
    if (p < F + G + N + G) return 8'h80;
    if (p < F + G + N + G + N) return {1'b0, pat(c)};
    return 8'h80;
  endfunction

  task automatic chk_disp(input string req, input logic [7:0] exp);
    n_chk++;
    if ({blank, seg} !== exp) begin
      n_bad++;
      $display("FAIL %s: {blank,seg} actual %h expected %h at %0t", req, {blank, seg}, exp, $time);
    end
  endtask

  task automatic chk_speed(input string req, input logic [2:0] exp);
    n_chk++;
    if (speed !== exp) begin
      n_bad++;
      $display("FAIL %s: speed actual %0d expected %0d at %0t", req, speed, exp, $time);
    end
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk);
    #1;
  endtask

  task automatic run_cycle(input string req, input int a, input int b, input int c, input int reps);
    for (int i = 0; i < PER * reps; i++) begin
      chk_disp(req, exp_at(i % PER, a, b, c));
      step(1);
    end
  endtask

  task automatic t_reset;
    rst_n = 0;
    step(3);
    rst_n = 1;
    #1;
    chk_speed("R1 reset speed", 3'd3);
    chk_disp("R1 reset first digit", {1'b0, pat(3)});
  endtask

  task automatic t_sequence;
    run_cycle("R2 R4 R5 kHz cycle", 3, 4, 5, 2);
  endtask

  task automatic t_tick_gate;
    step(2);
    ms_tick = 0;
    for (int i = 0; i < 10; i++) begin
      step(1);
      chk_disp("R6 frozen without tick", {1'b0, pat(3)});
    end
    ms_tick = 1;
    step(2);
    chk_disp("R6 still first digit", {1'b0, pat(3)});
    step(1);
    chk_disp("R6 gap after resume", 8'h80);
  endtask

  task automatic t_hold_release;
    step(4);
    up_btn = 1;
    for (int i = 0; i < PER + 3; i++) begin
      step(1);
      chk_disp("R7 dark while up held", 8'h80);
    end
    up_btn = 0;
    down_btn = 1;
    step(5);
    chk_disp("R7 dark while down held", 8'h80);
    down_btn = 0;
    step(1);
    run_cycle("R8 restart after release", 3, 4, 5, 1);
    step(PER - 2);
    down_btn = 1;
    step(1);
    down_btn = 0;
    step(1);
    chk_disp("R8 restart from rest", {1'b0, pat(3)});
    step(F - 1);
    chk_disp("R8 full first digit", {1'b0, pat(3)});
    step(1);
    chk_disp("R8 gap after full first", 8'h80);
  endtask

  task automatic t_speed;
    speed_btn = 1;
    step(1);
    chk_disp("R9 shows speed", {1'b0, pat(3)});
    up_btn = 1;
    step(ST - 1);
    chk_speed("R10 not yet stepped", 3'd3);
    step(1);
    chk_speed("R10 stepped up", 3'd4);
    chk_disp("R9 shows new speed", {1'b0, pat(4)});
    step(2 * ST + 3 * ST);
    chk_speed("R11 held at 6", 3'd6);
    chk_disp("R11 display 6", {1'b0, pat(6)});
    down_btn = 1;
    step(3 * ST);
    chk_speed("R10 both held no step", 3'd6);
    up_btn = 0;
    step(5 * ST + 3 * ST);
    chk_speed("R11 held at 1", 3'd1);
    chk_disp("R9 display 1", {1'b0, pat(1)});
    down_btn = 0;
    up_btn = 1;
    step(4 * ST);
    chk_speed("R10 climbed to 5", 3'd5);
    up_btn = 0;
    step(3);
    chk_disp("R9 speed without tuning", {1'b0, pat(5)});
    speed_btn = 0;
    step(1);
    run_cycle("R3 wide digits at speed 5", 2, 1, 3, 1);
  endtask

  task automatic t_narrow_again;
    speed_btn = 1;
    down_btn = 1;
    step(ST);
    chk_speed("R10 down to 4", 3'd4);
    speed_btn = 0;
    down_btn = 0;
    step(1);
    run_cycle("R4 narrow digits at speed 4", 3, 4, 5, 1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run incomplete actual timeout expected finish");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_sequence();
    t_tick_gate();
    t_hold_release();
    t_speed();
    t_narrow_again();
    finish_run();
  end
endmodule